// File: doc/BRIEF.md
# Length-Selected Transport CRC Unit

This block attaches or verifies the cyclic redundancy check of one transport block per frame. Payload arrives one bit per cycle with a valid strobe and an end-of-frame flag. A declared payload length travels beside the first bit, and that length alone decides which generator is used. Payloads of up to 3824 bits get a 16-bit check. Longer payloads, up to 1,277,992 bits, get a 24-bit check.

In generate mode the payload bits come out one cycle after they are taken in. Right after the final payload bit, the block streams out the parity bits, highest order first. While it does this it refuses new input. In check mode the block takes in the payload followed by its parity and divides all of it. One cycle after the final bit it raises a done pulse, together with a pass flag that is true when the remainder is zero. The operating mode and the generator choice are sampled on the first bit of a frame. They then stay fixed until that frame ends.

Top module: `txcrc_unit`

## Requirements
- R1: After reset, and right after a reset taken in the middle of a frame, `out_valid`, `out_last` and `chk_done` are low and `in_ready` is high.
- R2: When the declared length is at most 3824, the generator is x^16+x^12+x^5+1 (0x1021 without its top term), and a generate frame carries exactly 16 parity bits.
- R3: When the declared length is above 3824, the generator is the 24-bit one with terms 24,23,18,17,14,11,10,7,6,5,4,3,1,0 (0x864CFB without its top term), and a generate frame carries exactly 24 parity bits.
- R4: In generate mode, output bit k equals accepted payload bit k, delayed by one cycle. The parity follows with no gap, highest-order bit first, and `out_last` is high on the final parity bit only.
- R5: While parity is being sent, `in_ready` is low and any `in_valid`, `in_bit` or `in_last` has no effect on the output stream.
- R6: The remainder starts at zero for each frame and is sent without inversion, so an all-zero payload gets all-zero parity.
- R7: In check mode, `chk_done` pulses one cycle after the accepted bit that carries `in_last`. `chk_pass` is high in that cycle exactly when the remainder over payload plus parity is zero.
- R8: The mode and the generator are taken from `op_chk` and `blk_len` on the first accepted bit of a frame. Changes to either input later in the frame have no effect.
- R9: A check-mode frame produces no `out_valid`.
- R10: `in_ready` is high again in the cycle in which `out_last` is presented, so a new frame can start on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_chk | input | 1 | 0 = generate and append parity, 1 = check a received frame; sampled on the first bit |
| blk_len | input | 21 | Declared payload length in bits; sampled on the first bit |
| in_valid | input | 1 | Input bit is valid |
| in_bit | input | 1 | Serial input bit |
| in_last | input | 1 | Final input bit of the frame (payload end in generate, parity end in check) |
| in_ready | output | 1 | Block can take an input bit this cycle |
| out_valid | output | 1 | Output bit is valid (generate mode only) |
| out_bit | output | 1 | Serial output bit |
| out_last | output | 1 | Final parity bit of a generated frame |
| chk_done | output | 1 | One-cycle pulse at the end of a checked frame |
| chk_pass | output | 1 | Remainder was zero; meaningful with `chk_done` |

## Verification
The two functions that can land in the same cycle are parity emission and an upstream that keeps offering input. The bench provokes this by holding `in_valid` and `in_last` high with changing data through every parity cycle of one frame. It judges the result by checking that the emitted parity still equals an independent polynomial-division result and that no extra bits appear. The second meeting point is the cycle where the last parity bit leaves and the next frame may already begin. The bench checks that `in_ready` is high in that same cycle and then starts the next frame without idle time. Frames of lengths 3824 and 3825 check the generator switch on both sides of the boundary.

// File: rtl/txcrc_pkg.sv
package txcrc_pkg;
  localparam int NARROW_W = 16;
  localparam int WIDE_W = 24;
  localparam logic [WIDE_W-1:0] NARROW_POLY = 24'h001021;
  localparam logic [WIDE_W-1:0] WIDE_POLY = 24'h864CFB;
  localparam int LEN_W = 21;
  localparam int NARROW_MAX_LEN = 3824;

  typedef enum logic {OP_GEN = 1'b0, OP_CHK = 1'b1} op_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_BODY = 2'd1, S_TAIL = 2'd2} seq_e;
endpackage

// File: rtl/txcrc_lensel.sv
// Frame attribute latch: mode and generator choice, captured on the first bit.
module txcrc_lensel #(
  parameter int LW   = txcrc_pkg::LEN_W,
  parameter int MAXN = txcrc_pkg::NARROW_MAX_LEN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sop,
  input  logic          op_in,
  input  logic [LW-1:0] len,
  output logic          wide_now,
  output logic          op_now
);
  localparam logic [LW-1:0] THR = LW'(MAXN);

  logic wide_r;
  logic op_r;
  logic wide_in;

  assign wide_in = (len > THR);

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_r <= 1'b0;
      op_r   <= 1'b0;
    end else if (sop) begin
      wide_r <= wide_in;
      op_r   <= op_in;
    end
  end

  // Within the start cycle the fresh values apply; afterwards the latched ones.
  assign wide_now = sop ? wide_in : wide_r;
  assign op_now   = sop ? op_in   : op_r;

  // R8: outside a start cycle the choice in use does not move
  a_r8_hold_choice: assert property (@(posedge clk) disable iff (rst)
    (!sop) |=> (!sop) |-> (wide_now == $past(wide_now)));
endmodule

// File: rtl/txcrc_lfsr.sv
// Remainder register: one division step per accepted bit, or a plain shift
// while the parity is read out highest order first.
module txcrc_lfsr #(
  parameter int RW = txcrc_pkg::WIDE_W,
  parameter int SW = txcrc_pkg::NARROW_W,
  parameter logic [RW-1:0] RPOLY = txcrc_pkg::WIDE_POLY,
  parameter logic [RW-1:0] SPOLY = txcrc_pkg::NARROW_POLY
) (
  input  logic clk,
  input  logic rst,
  input  logic step_en,
  input  logic init,
  input  logic din,
  input  logic wide,
  input  logic shift_en,
  output logic nxt_zero,
  output logic msb
);
  localparam logic [RW-1:0] SMASK = {{(RW-SW){1'b0}}, {SW{1'b1}}};
  localparam logic [RW-1:0] RMASK = {RW{1'b1}};

  logic [RW-1:0] rem_q;
  logic [RW-1:0] seed;
  logic [RW-1:0] rem_step;
  logic [RW-1:0] rem_shift;

  function automatic logic [RW-1:0] step_f(input logic [RW-1:0] r,
                                           input logic b, input logic w);
    logic top;
    logic [RW-1:0] s;
    top = w ? r[RW-1] : r[SW-1];
    s = (r << 1) & (w ? RMASK : SMASK);
    if (b ^ top) s = s ^ (w ? RPOLY : SPOLY);
    return s;
  endfunction

  assign seed      = init ? '0 : rem_q;
  assign rem_step  = step_f(seed, din, wide);
  assign rem_shift = (rem_q << 1) & (wide ? RMASK : SMASK);
  assign nxt_zero  = (rem_step == '0);
  assign msb       = wide ? rem_q[RW-1] : rem_q[SW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (step_en) begin
      rem_q <= rem_step;
    end else if (shift_en) begin
      rem_q <= rem_shift;
    end
  end

  // R5: the remainder is never stepped by input while it is being read out
  a_r5_step_or_shift: assert property (@(posedge clk) disable iff (rst)
    step_en |-> !shift_en);
  // R2: a narrow-generator step leaves the upper remainder bits clear
  a_r2_narrow_clean: assert property (@(posedge clk) disable iff (rst)
    (step_en && !wide) |=> (rem_q[RW-1:SW] == '0));
endmodule

// File: rtl/txcrc_seq.sv
// Frame sequencer: payload pass-through, parity tail, check verdict.
module txcrc_seq #(
  parameter int RW = txcrc_pkg::WIDE_W,
  parameter int SW = txcrc_pkg::NARROW_W
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_last,
  input  logic op_now,
  input  logic wide_now,
  input  logic msb,
  input  logic nxt_zero,
  output logic in_ready,
  output logic sop,
  output logic step_en,
  output logic shift_en,
  output logic out_valid,
  output logic out_bit,
  output logic out_last,
  output logic chk_done,
  output logic chk_pass
);
  import txcrc_pkg::*;

  localparam int CW = $clog2(RW + 1);

  seq_e          st_q;
  logic [CW-1:0] pcnt;
  logic          acc;

  assign in_ready = (st_q != S_TAIL);
  assign acc      = in_valid & in_ready;
  assign sop      = acc & (st_q == S_IDLE);
  assign step_en  = acc;
  assign shift_en = (st_q == S_TAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      pcnt      <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_last  <= 1'b0;
      chk_done  <= 1'b0;
      chk_pass  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      chk_done  <= 1'b0;
      chk_pass  <= 1'b0;
      if (st_q == S_TAIL) begin
        out_valid <= 1'b1;
        out_bit   <= msb;
        if (pcnt == '0) begin
          out_last <= 1'b1;
          st_q     <= S_IDLE;
        end else begin
          pcnt <= pcnt - 1'b1;
        end
      end else if (acc) begin
        if (op_now == OP_CHK) begin
          if (in_last) begin
            chk_done <= 1'b1;
            chk_pass <= nxt_zero;
            st_q     <= S_IDLE;
          end else begin
            st_q <= S_BODY;
          end
        end else begin
          out_valid <= 1'b1;
          out_bit   <= in_bit;
          if (in_last) begin
            st_q <= S_TAIL;
            pcnt <= wide_now ? CW'(RW - 1) : CW'(SW - 1);
          end else begin
            st_q <= S_BODY;
          end
        end
      end
    end
  end

  // R5: input is refused only while parity bits are streaming out
  a_r5_tail_busy: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> out_valid);
  // R4: the frame end marker never stands alone
  a_r4_last_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R7: a pass verdict appears only with the done pulse
  a_r7_pass_done: assert property (@(posedge clk) disable iff (rst)
    chk_pass |-> chk_done);
  // R9: a check-mode bit never produces output
  a_r9_chk_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc && op_now == OP_CHK) |=> !out_valid);
  // R3: the tail counter stays inside the widest parity
  a_r3_tail_count: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_TAIL) |-> (pcnt < CW'(RW)));
  // R10: input reopens as the final parity bit is presented
  a_r10_reopen: assert property (@(posedge clk) disable iff (rst)
    out_last |-> in_ready);
endmodule

// File: rtl/txcrc_unit.sv
module txcrc_unit #(
  parameter int LW   = txcrc_pkg::LEN_W,
  parameter int MAXN = txcrc_pkg::NARROW_MAX_LEN,
  parameter int RW   = txcrc_pkg::WIDE_W,
  parameter int SW   = txcrc_pkg::NARROW_W,
  parameter logic [RW-1:0] RPOLY = txcrc_pkg::WIDE_POLY,
  parameter logic [RW-1:0] SPOLY = txcrc_pkg::NARROW_POLY
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_chk,
  input  logic [LW-1:0] blk_len,
  input  logic          in_valid,
  input  logic          in_bit,
  input  logic          in_last,
  output logic          in_ready,
  output logic          out_valid,
  output logic          out_bit,
  output logic          out_last,
  output logic          chk_done,
  output logic          chk_pass
);
  logic sop;
  logic step_en;
  logic shift_en;
  logic wide_now;
  logic op_now;
  logic nxt_zero;
  logic msb;

  txcrc_lensel #(.LW(LW), .MAXN(MAXN)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .sop      (sop),
    .op_in    (op_chk),
    .len      (blk_len),
    .wide_now (wide_now),
    .op_now   (op_now)
  );

  txcrc_lfsr #(.RW(RW), .SW(SW), .RPOLY(RPOLY), .SPOLY(SPOLY)) u_rem (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .init     (sop),
    .din      (in_bit),
    .wide     (wide_now),
    .shift_en (shift_en),
    .nxt_zero (nxt_zero),
    .msb      (msb)
  );

  txcrc_seq #(.RW(RW), .SW(SW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .in_last   (in_last),
    .op_now    (op_now),
    .wide_now  (wide_now),
    .msb       (msb),
    .nxt_zero  (nxt_zero),
    .in_ready  (in_ready),
    .sop       (sop),
    .step_en   (step_en),
    .shift_en  (shift_en),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_last  (out_last),
    .chk_done  (chk_done),
    .chk_pass  (chk_pass)
  );
endmodule

// File: tb/sim_txcrc_unit.sv
module sim_txcrc_unit;
  localparam int LW = 21;
  localparam int MAXB = 4200;
  localparam int NV = 12;
  // fields: length, mode (1 = check), seed (0 = all zeros), flip parity bit,
  // junk input during tail, change length mid-frame
  localparam int VEC [NV][6] = '{
    '{1,    0, 1,  0, 0, 0},
    '{40,   0, 5,  0, 0, 0},
    '{3824, 0, 7,  0, 0, 0},
    '{3825, 0, 9,  0, 0, 0},
    '{64,   0, 0,  0, 0, 0},
    '{57,   0, 11, 0, 1, 0},
    '{30,   0, 13, 0, 0, 1},
    '{3900, 0, 17, 0, 0, 1},
    '{100,  1, 19, 0, 0, 0},
    '{100,  1, 19, 1, 0, 0},
    '{3825, 1, 23, 0, 0, 0},
    '{3824, 1, 29, 1, 0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_chk = 1'b0;
  logic [LW-1:0] blk_len = '0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_last = 1'b0;
  logic in_ready, out_valid, out_bit, out_last, chk_done, chk_pass;

  int total = 0;
  int bad = 0;
  bit pay [0:MAXB-1];
  bit cap [0:MAXB-1];

  always #2 clk = ~clk;

  txcrc_unit u0 (
    .clk(clk), .rst(rst), .op_chk(op_chk), .blk_len(blk_len),
    .in_valid(in_valid), .in_bit(in_bit), .in_last(in_last),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
    .out_last(out_last), .chk_done(chk_done), .chk_pass(chk_pass)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Textbook long division of payload * x^w by the generator.
  function automatic logic [23:0] model_crc(input int n, input bit wide);
    int w;
    logic [23:0] g;
    logic [23:0] m;
    logic [23:0] r;
    logic top;
    logic b;
    w = wide ? 24 : 16;
    g = wide ? 24'h864CFB : 24'h001021;
    m = wide ? 24'hFFFFFF : 24'h00FFFF;
    r = '0;
    for (int k = 0; k < n + w; k++) begin
      b = (k < n) ? pay[k] : 1'b0;
      top = r[w-1];
      r = ((r << 1) | {23'd0, b}) & m;
      if (top) r = r ^ g;
    end
    return r;
  endfunction

  task automatic fill(input int len, input int seed);
    logic [15:0] x;
    x = seed[15:0];
    for (int j = 0; j < len; j++) begin
      x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
      pay[j] = (seed == 0) ? 1'b0 : x[0];
    end
  endtask

  task automatic run_vec(input int v);
    int len, op, seed, flip, junk, lm, w, tot, i, ncap, lastcnt, lastat, cyc, errs;
    bit wide, sawdone, passv, rdy_last, chkout;
    logic [23:0] par, got;
    string tag;
    len = VEC[v][0]; op = VEC[v][1]; seed = VEC[v][2];
    flip = VEC[v][3]; junk = VEC[v][4]; lm = VEC[v][5];
    wide = (len > 3824);
    w = wide ? 24 : 16;
    fill(len, seed);
    par = model_crc(len, wide);
    tot = len;
    if (op == 1) begin
      for (int j = 0; j < w; j++)
        pay[len + j] = par[w-1-j] ^ ((flip != 0) && (j == 0));
      tot = len + w;
    end
    i = 0; ncap = 0; lastcnt = 0; lastat = -1; cyc = 0;
    sawdone = 0; passv = 0; rdy_last = 0; chkout = 0;
    while (cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (out_valid) begin
        if (op == 1) chkout = 1;
        if (ncap < MAXB) cap[ncap] = out_bit;
        ncap++;
        if (out_last) begin
          lastcnt++;
          lastat = ncap - 1;
          rdy_last = in_ready;
        end
      end
      if (chk_done) begin
        sawdone = 1;
        passv = chk_pass;
      end
      if (i == tot && ((op == 0) ? (lastcnt > 0) : sawdone)) break;
      op_chk = op[0];
      blk_len = (lm != 0 && i > 0) ? (wide ? LW'(10) : LW'(5000)) : LW'(len);
      if (in_ready && i < tot) begin
        in_valid = 1'b1;
        in_bit = pay[i];
        in_last = (i == tot - 1);
        i++;
      end else begin
        in_valid = (junk != 0) && !in_ready;
        in_bit = cyc[0];
        in_last = (junk != 0) && !in_ready;
      end
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    if (op == 0) begin
      tag = wide ? "R3" : "R2";
      if (seed == 0) tag = "R6";
      if (junk != 0) tag = "R5";
      if (lm != 0) tag = "R8";
      chk(ncap == len + w, wide ? "R3 frame length" : "R2 frame length", ncap, len + w);
      errs = 0;
      for (int j = 0; j < len && j < MAXB; j++) if (cap[j] != pay[j]) errs++;
      chk(errs == 0, "R4 payload bits", errs, 0);
      got = '0;
      for (int j = 0; j < w; j++)
        if (len + j < MAXB) got[w-1-j] = cap[len + j];
      chk(got == par, {tag, " parity value"}, int'(got), int'(par));
      if (seed == 0) chk(got == '0, "R6 zero payload parity", int'(got), 0);
      chk(lastcnt == 1 && lastat == len + w - 1, "R4 last marker", lastat, len + w - 1);
      chk(rdy_last, "R10 ready at last", rdy_last, 1);
    end else begin
      chk(sawdone, "R7 done pulse", sawdone, 1);
      chk(passv == (flip == 0), "R7 pass verdict", passv, flip == 0);
      chk(!chkout, "R9 no output in check", chkout, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk(out_valid == 0 && out_last == 0, "R1 reset outputs", out_valid, 0);
    chk(chk_done == 0, "R1 reset done", chk_done, 0);
    chk(in_ready == 1, "R1 reset ready", in_ready, 1);
    for (int v = 0; v < NV; v++) run_vec(v);
    // R1: reset taken during the parity tail
    fill(10, 3);
    op_chk = 1'b0;
    blk_len = LW'(10);
    for (int j = 0; j < 10; j++) begin
      in_valid = 1'b1;
      in_bit = pay[j];
      in_last = (j == 9);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    @(negedge clk);
    chk(in_ready == 0, "R5 tail refuses input", in_ready, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(in_ready == 1 && out_valid == 0, "R1 reset mid-tail", out_valid, 0);
    run_vec(1);
    summary();
  end
endmodule